// File: doc/BRIEF.md
# Write-Protect Key Guard with Init-Mode Handshake

This block sits in front of the configuration registers of a clock/calendar unit. Software can change nothing there until it writes an exact pair of key bytes to a key register. Any other key value closes the guard again. Behind the guard are four registers: the key register, a control register, a prescaler register and a calibration register. The prescaler and the hour-format bit also require init mode. In init mode the slow-clock counters are frozen so that they can be reloaded safely.

Init mode is requested with a control bit in the bus clock domain. The request passes through a two-flop synchronizer into the slow clock domain, and the slow domain's acknowledge returns through a second two-flop synchronizer. The returned acknowledge is the init-flag status. Software polls it before it writes the prescaler or the format. Clearing the request bit takes the same path back and returns the block to free-running mode. The configuration values are driven out as ports to the counter logic.

Top module: `rtc_guard`

## Requirements
- R1: After reset `locked` is 1, `initf` is 0, `init_req` is 0, and the control, prescaler and calibration registers read 0.
- R2: A key-register write (address 0) of 0xCA followed by a key-register write of 0x53 drives `locked` low in the cycle after the second write. Other register writes in between do not break the sequence.
- R3: Any key-register write that does not complete the sequence leaves `locked` high. A write of 0xCA always restarts the sequence. Any other byte, including a wrong second key, sets `locked` high.
- R4: While `locked` is high, writes to the control (address 1), prescaler (address 2) and calibration (address 3) registers are ignored, and their contents stay unchanged.
- R5: While unlocked, a write to the calibration register takes effect whether or not init mode is active.
- R6: While unlocked, control bit 0 sets or clears the init request, which is driven out on `init_req`.
- R7: `initf` rises only after the request has crossed two slow-clock flops and two bus-clock flops, which is never sooner than two slow-clock edges after the request is set.
- R8: Clearing the init request returns `initf` to 0 through the same synchronizer path.
- R9: The prescaler register and control bit 1 (24-hour format, 1 = 24 h) change only when the block is unlocked and `initf` is 1. At any other time such writes leave them unchanged.
- R10: Reads are combinational on `addr`. Address 0 reads 0. Address 1 reads {initf at bit 2, format at bit 1, init request at bit 0}. Addresses 2 and 3 read the prescaler and the calibration value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| slow_clk | input | 1 | Slow counter clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en | input | 1 | Write strobe |
| addr | input | AW | Register address |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for `addr` |
| locked | output | 1 | Write protection active |
| initf | output | 1 | Init mode entered (synchronized acknowledge) |
| init_req | output | 1 | Init mode request |
| presc | output | DW | Prescaler value to counters |
| fmt24 | output | 1 | 24-hour format select |
| calib | output | DW | Calibration value |

## Verification
The bound checker checks on every bus cycle that nothing protected changes while `locked` is high. It also checks that the prescaler and format hold while `initf` is low, that any key byte other than the expected ones leaves the block locked, and that `locked` falls only after a 0x53 key write. The bench covers what needs a history of writes or the clock-domain crossing. It runs random key sequences against a reference model of the unlock state and measures the latency of `initf` in both directions. It also checks directed cases: a wrong second key, a repeated first key, and writes to the prescaler and format attempted outside init mode.

// File: rtl/rtc_guard.sv
module rtc_guard #(
  parameter int DW = 16,
  parameter int AW = 2,
  parameter logic [7:0] KEY_A = 8'hCA,
  parameter logic [7:0] KEY_B = 8'h53
) (
  input  logic          clk,
  input  logic          slow_clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          locked,
  output logic          initf,
  output logic          init_req,
  output logic [DW-1:0] presc,
  output logic          fmt24,
  output logic [DW-1:0] calib
);
  localparam logic [AW-1:0] A_KEY   = AW'(0);
  localparam logic [AW-1:0] A_CTRL  = AW'(1);
  localparam logic [AW-1:0] A_PRESC = AW'(2);
  localparam logic [AW-1:0] A_CALIB = AW'(3);

  typedef enum logic [1:0] {K_SHUT, K_HALF, K_OPEN} key_st_e;
  key_st_e key_st;

  logic [7:0] key_byte;
  logic       wr_key, wr_ctrl, wr_presc, wr_calib;
  logic [1:0] req_sync;
  logic [1:0] ack_sync;

  assign key_byte = wdata[7:0];
  assign wr_key   = wr_en && addr == A_KEY;
  assign wr_ctrl  = wr_en && addr == A_CTRL  && !locked;
  assign wr_presc = wr_en && addr == A_PRESC && !locked && initf;
  assign wr_calib = wr_en && addr == A_CALIB && !locked;
  assign locked   = key_st != K_OPEN;
  assign initf    = ack_sync[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      key_st <= K_SHUT;
    else if (wr_key) begin
      if (key_byte == KEY_A)
        key_st <= K_HALF;
      else if (key_st == K_HALF && key_byte == KEY_B)
        key_st <= K_OPEN;
      else
        key_st <= K_SHUT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_req <= 1'b0;
      fmt24    <= 1'b0;
      presc    <= '0;
      calib    <= '0;
    end else begin
      if (wr_ctrl) begin
        init_req <= wdata[0];
        if (initf) fmt24 <= wdata[1];
      end
      if (wr_presc) presc <= wdata;
      if (wr_calib) calib <= wdata;
    end
  end

  always_ff @(posedge slow_clk or negedge rst_n) begin
    if (!rst_n) req_sync <= 2'b00;
    else        req_sync <= {req_sync[0], init_req};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_sync <= 2'b00;
    else        ack_sync <= {ack_sync[0], req_sync[1]};
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_CTRL:  rdata[2:0] = {initf, fmt24, init_req};
      A_PRESC: rdata = presc;
      A_CALIB: rdata = calib;
      default: rdata = '0;
    endcase
  end
endmodule

module rtc_guard_chk #(
  parameter int DW = 16,
  parameter int AW = 2,
  parameter logic [7:0] KEY_A = 8'hCA,
  parameter logic [7:0] KEY_B = 8'h53
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic          locked,
  input logic          initf,
  input logic          init_req,
  input logic [DW-1:0] presc,
  input logic          fmt24,
  input logic [DW-1:0] calib
);
  // R4
  locked_presc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(presc));
  // R4
  locked_calib_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(calib));
  // R4
  locked_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(init_req));
  // R9
  noinit_presc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !initf |=> $stable(presc));
  // R9
  noinit_fmt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !initf |=> $stable(fmt24));
  // R3
  bad_key_relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == '0 && wdata[7:0] != KEY_B) |=> locked);
  // R2
  unlock_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(wr_en && addr == '0 && wdata[7:0] == KEY_B));
endmodule

bind rtc_guard rtc_guard_chk #(.DW(DW), .AW(AW), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .locked(locked), .initf(initf), .init_req(init_req), .presc(presc),
  .fmt24(fmt24), .calib(calib)
);

// File: tb/rtc_guard_tb.sv
module rtc_guard_tb;
  localparam int DW = 16;
  localparam int AW = 2;

  logic clk = 0, slow_clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata, presc, calib;
  logic locked, initf, init_req, fmt24;

  int n_run = 0, n_fail = 0;
  int m_st = 0;                 // 0 shut, 1 half, 2 open
  logic [DW-1:0] m_calib = '0, m_presc = '0;
  bit done = 0;

  always #2 clk = ~clk;
  always #20 slow_clk = ~slow_clk;

  rtc_guard u_dut (.clk(clk), .slow_clk(slow_clk), .rst_n(rst_n), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .locked(locked), .initf(initf),
    .init_req(init_req), .presc(presc), .fmt24(fmt24), .calib(calib));

  function automatic int key_next(int st, logic [7:0] k);
    if (k == 8'hCA) return 1;
    if (st == 1 && k == 8'h53) return 2;
    return 0;
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
    if (a == 0) m_st = key_next(m_st, d[7:0]);
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_initf(logic lvl, output int cyc);
    cyc = 0;
    while (initf !== lvl && cyc < 200) begin
      @(negedge clk); cyc++;
    end
  endtask

  initial begin
    #400000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    int cyc;
    void'($urandom(32'd4242));
    #13 rst_n = 1;
    @(negedge clk);
    // R1
    check("R1 locked", locked, 1);
    check("R1 initf", initf, 0);
    check("R1 init_req", init_req, 0);
    rd(1, d); check("R1 ctrl", d, 0);
    rd(2, d); check("R1 presc", d, 0);
    rd(3, d); check("R1 calib", d, 0);
    // R10 key reads zero
    rd(0, d); check("R10 key read", d, 0);

    // R4 locked writes ignored
    wr(3, 16'h1234); wr(1, 16'h3); wr(2, 16'h7);
    rd(3, d); check("R4 calib", d, 0);
    check("R4 init_req", init_req, 0);
    rd(2, d); check("R4 presc", d, 0);

    // R3 wrong second key, then repeated first key
    wr(0, 16'hCA); wr(0, 16'h35);
    check("R3 wrong second", locked, 1);
    wr(0, 16'hCA); wr(0, 16'hCA); wr(0, 16'h53);
    check("R3 repeated first key", locked, 0);
    wr(0, 16'h00);
    check("R3 relock 00", locked, 1);

    // R2 with intervening register write
    wr(0, 16'hCA); wr(3, 16'h55); wr(0, 16'h53);
    check("R2 unlock", locked, 0);
    // R5 calib without init
    wr(3, 16'hBEEF); m_calib = 16'hBEEF;
    rd(3, d); check("R5 calib", d, 16'hBEEF);
    // R9 presc/fmt outside init
    wr(2, 16'h00FF); wr(1, 16'h2);
    rd(2, d); check("R9 presc no init", d, 0);
    check("R9 fmt no init", fmt24, 0);

    // R6/R7 init handshake
    wr(1, 16'h1);
    check("R6 init_req", init_req, 1);
    check("R7 initf not immediate", initf, 0);
    wait_initf(1, cyc);
    n_run++;
    if (initf !== 1 || cyc < 8 || cyc > 40) begin
      n_fail++; $display("FAIL R7: actual latency %0d expected 8..40", cyc);
    end
    rd(1, d); check("R10 ctrl read", d, 16'h5);
    // R9 writes in init
    wr(2, 16'h7FFF); m_presc = 16'h7FFF;
    wr(1, 16'h3);
    rd(2, d); check("R9 presc in init", d, 16'h7FFF);
    check("R9 fmt in init", fmt24, 1);
    rd(1, d); check("R10 ctrl read2", d, 16'h7);
    // R8 leave init
    wr(1, 16'h2);
    check("R8 req cleared", init_req, 0);
    wait_initf(0, cyc);
    n_run++;
    if (initf !== 0 || cyc < 8 || cyc > 40) begin
      n_fail++; $display("FAIL R8: actual latency %0d expected 8..40", cyc);
    end
    wr(2, 16'h0001); wr(1, 16'h0);
    rd(2, d); check("R9 presc after exit", d, 16'h7FFF);
    check("R9 fmt after exit", fmt24, 1);

    // R2/R3/R4/R5 random key traffic
    for (int i = 0; i < 400; i++) begin
      int sel = $urandom % 4;
      logic [7:0] k;
      logic [DW-1:0] v;
      k = (sel == 0) ? 8'hCA : (sel == 1) ? 8'h53 : 8'($urandom);
      if (sel != 3) wr(0, {8'h00, k});
      v = DW'($urandom);
      wr(3, v);
      if (m_st == 2) m_calib = v;
      if ($urandom % 4 == 0) wr(2, DW'($urandom));
      check("R3 rand locked", locked, (m_st == 2) ? 0 : 1);
      rd(3, d); check("R4/R5 rand calib", d, m_calib);
      rd(2, d); check("R9 rand presc", d, m_presc);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule